// File: doc/BRIEF.md
# Operand Forwarding Unit

This block steers operands in a five-stage integer pipeline so that a result can be used before it is written back. Each source register number of the instruction now in execute is compared with the destination register of the two older instructions. The first of these sits in the execute/memory pipeline register and the second in the memory/writeback pipeline register. From those comparisons the block produces a select code for each ALU operand multiplexer. The code picks the register-file value, the newer result or the older result.

A second path serves stores, which need their data only in the memory stage. When the store now in the memory stage wants a register that the instruction just ahead of it (now in writeback, typically a load) is about to write, the block steers the writeback value into the store-data path. The selects are purely combinational from the current pipeline-register contents. The register file is assumed to write in the first half of a cycle and read in the second half, so nothing is bypassed from writeback into decode. An instruction three or more behind its producer therefore reads the register file normally.

Top module: `fwd_unit`

## Requirements
- R1: With no qualifying producer match, an operand select is 0 (register file); this also holds for an idle pipeline and for a producer three or more instructions ahead.
- R2: When the execute/memory stage is valid, has its write enable set, and has a nonzero destination equal to an operand's source, that operand's select is 1 (execute/memory result).
- R3: When only the memory/writeback stage is valid, write-enabled and has a nonzero destination equal to an operand's source, that operand's select is 2 (memory/writeback result).
- R4: When both stages qualify for the same operand, the select is 1, because the execute/memory stage holds the younger value.
- R5: A source or destination of register 0 is never forwarded; the select falls to 0 unless another qualifying match exists.
- R6: A stage whose valid bit or write-enable bit is low is not used as a bypass source; the operand falls to the other stage or to 0.
- R7: The two operand selects are decided independently; op_sel_o[1:0] belongs to operand A and op_sel_o[3:2] to operand B.
- R8: st_fwd_o is 1 exactly when the execute/memory stage is a valid store and the memory/writeback stage is valid, write-enabled, and has a nonzero destination equal to the store's data register; otherwise it is 0.
- R9: All outputs follow input changes within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_i | input | NUM_OPS*REG_W | Source register numbers of the execute-stage instruction, operand 0 in the low field |
| exmem_valid_i | input | 1 | Execute/memory stage holds a real instruction |
| exmem_wen_i | input | 1 | Execute/memory instruction writes a register |
| exmem_rd_i | input | REG_W | Execute/memory destination register |
| exmem_store_i | input | 1 | Execute/memory instruction is a store |
| exmem_st_src_i | input | REG_W | Data register number of that store |
| memwb_valid_i | input | 1 | Memory/writeback stage holds a real instruction |
| memwb_wen_i | input | 1 | Memory/writeback instruction writes a register |
| memwb_rd_i | input | REG_W | Memory/writeback destination register |
| op_sel_o | output | NUM_OPS*2 | Per-operand mux select: 0 register file, 1 execute/memory, 2 memory/writeback |
| st_fwd_o | output | 1 | Store-data mux takes the memory/writeback value |

## Verification
The block holds no state, so any fault shows at the select ports in the same cycle as the stimulus that exposes it. A wrong priority shows up when both stages match one source and the select reads 2 instead of 1. A missing qualifier shows up as a nonzero select for register 0, or for a stage that is invalid or not writing. The bench drives dependency patterns that place producers one, two and three instructions ahead, covering each operand and the store path, plus a long stream of mixed patterns over a small register range so that matches happen often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'd0,
    FWD_EXMEM = 2'd1,
    FWD_MEMWB = 2'd2
  } fwd_sel_e;

  localparam int SEL_W = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic             valid_i,
  input  logic             wen_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src_i,
  output logic             hit_o
);
  // a stage qualifies only when it is real, writes, and targets a nonzero register
  assign hit_o = valid_i & wen_i & (dst_i != '0) & (dst_i == src_i);
endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             [REG_W-1:0] src_i,
  input  logic                         exmem_valid_i,
  input  logic                         exmem_wen_i,
  input  logic             [REG_W-1:0] exmem_rd_i,
  input  logic                         memwb_valid_i,
  input  logic                         memwb_wen_i,
  input  logic             [REG_W-1:0] memwb_rd_i,
  output fwd_sel_e                     sel_o
);
  logic hit_ex, hit_wb;

  fwd_match #(.REG_W(REG_W)) u_ex_cmp (
    .valid_i(exmem_valid_i), .wen_i(exmem_wen_i),
    .dst_i(exmem_rd_i), .src_i(src_i), .hit_o(hit_ex)
  );

  fwd_match #(.REG_W(REG_W)) u_wb_cmp (
    .valid_i(memwb_valid_i), .wen_i(memwb_wen_i),
    .dst_i(memwb_rd_i), .src_i(src_i), .hit_o(hit_wb)
  );

  // younger result wins
  always_comb begin
    if (hit_ex)      sel_o = FWD_EXMEM;
    else if (hit_wb) sel_o = FWD_MEMWB;
    else             sel_o = FWD_RF;
  end

  always_comb begin
    if (!$isunknown({src_i, exmem_valid_i, exmem_wen_i, exmem_rd_i,
                     memwb_valid_i, memwb_wen_i, memwb_rd_i})) begin
      // R4
      ex_prio_chk: assert (!hit_ex || sel_o == FWD_EXMEM);
      // R5
      zero_reg_chk: assert (src_i != '0 || sel_o == FWD_RF);
      // R6
      wb_gate_chk: assert (sel_o != FWD_MEMWB || (memwb_valid_i && memwb_wen_i && memwb_rd_i == src_i));
      // R6
      ex_gate_chk: assert (sel_o != FWD_EXMEM || (exmem_valid_i && exmem_wen_i && exmem_rd_i == src_i));
    end
  end
endmodule

// File: rtl/fwd_store_pick.sv
module fwd_store_pick #(
  parameter int REG_W = 5
) (
  input  logic             exmem_valid_i,
  input  logic             exmem_store_i,
  input  logic [REG_W-1:0] exmem_st_src_i,
  input  logic             memwb_valid_i,
  input  logic             memwb_wen_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  output logic             st_fwd_o
);
  logic hit_wb;

  fwd_match #(.REG_W(REG_W)) u_st_cmp (
    .valid_i(memwb_valid_i), .wen_i(memwb_wen_i),
    .dst_i(memwb_rd_i), .src_i(exmem_st_src_i), .hit_o(hit_wb)
  );

  assign st_fwd_o = hit_wb & exmem_valid_i & exmem_store_i;

  always_comb begin
    if (!$isunknown({exmem_valid_i, exmem_store_i, exmem_st_src_i,
                     memwb_valid_i, memwb_wen_i, memwb_rd_i})) begin
      // R8
      st_gate_chk: assert (!st_fwd_o || (exmem_store_i && memwb_wen_i && memwb_rd_i == exmem_st_src_i));
      // R5
      st_zero_chk: assert (!st_fwd_o || exmem_st_src_i != '0);
    end
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_OPS = 2
) (
  input  logic [NUM_OPS-1:0][REG_W-1:0] ex_src_i,
  input  logic                          exmem_valid_i,
  input  logic                          exmem_wen_i,
  input  logic [REG_W-1:0]              exmem_rd_i,
  input  logic                          exmem_store_i,
  input  logic [REG_W-1:0]              exmem_st_src_i,
  input  logic                          memwb_valid_i,
  input  logic                          memwb_wen_i,
  input  logic [REG_W-1:0]              memwb_rd_i,
  output logic [NUM_OPS-1:0][SEL_W-1:0] op_sel_o,
  output logic                          st_fwd_o
);
  fwd_sel_e sel_w [NUM_OPS];

  generate
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
      fwd_src_pick #(.REG_W(REG_W)) u_pick (
        .src_i(ex_src_i[g]),
        .exmem_valid_i(exmem_valid_i), .exmem_wen_i(exmem_wen_i), .exmem_rd_i(exmem_rd_i),
        .memwb_valid_i(memwb_valid_i), .memwb_wen_i(memwb_wen_i), .memwb_rd_i(memwb_rd_i),
        .sel_o(sel_w[g])
      );
      assign op_sel_o[g] = sel_w[g];
    end
  endgenerate

  fwd_store_pick #(.REG_W(REG_W)) u_store (
    .exmem_valid_i(exmem_valid_i), .exmem_store_i(exmem_store_i),
    .exmem_st_src_i(exmem_st_src_i),
    .memwb_valid_i(memwb_valid_i), .memwb_wen_i(memwb_wen_i), .memwb_rd_i(memwb_rd_i),
    .st_fwd_o(st_fwd_o)
  );
endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int REG_W = 5;
  localparam int NUM_OPS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic [NUM_OPS-1:0][REG_W-1:0] ex_src;
  logic exv, exw, exst, mwv, mww;
  logic [REG_W-1:0] exrd, exss, mwrd;
  logic [NUM_OPS-1:0][1:0] op_sel;
  logic st_fwd;

  fwd_unit #(.REG_W(REG_W), .NUM_OPS(NUM_OPS)) dut_i (
    .ex_src_i(ex_src), .exmem_valid_i(exv), .exmem_wen_i(exw), .exmem_rd_i(exrd),
    .exmem_store_i(exst), .exmem_st_src_i(exss),
    .memwb_valid_i(mwv), .memwb_wen_i(mww), .memwb_rd_i(mwrd),
    .op_sel_o(op_sel), .st_fwd_o(st_fwd)
  );

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       st;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // expected select from the requirement text: R2/R4 newer first, R3 older, R5/R6 qualifiers
  function automatic logic [1:0] want_sel(logic [REG_W-1:0] s);
    if (exv && exw && exrd != 0 && exrd == s) return 2'd1;
    if (mwv && mww && mwrd != 0 && mwrd == s) return 2'd2;
    return 2'd0;
  endfunction

  task automatic drive(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                       input logic ev, input logic ew, input logic [REG_W-1:0] er,
                       input logic es, input logic [REG_W-1:0] ess,
                       input logic mv, input logic mw, input logic [REG_W-1:0] mr,
                       input string tag);
    exp_t e;
    @(negedge clk);
    ex_src[0] = a; ex_src[1] = b;
    exv = ev; exw = ew; exrd = er; exst = es; exss = ess;
    mwv = mv; mww = mw; mwrd = mr;
    e.a = want_sel(a);
    e.b = want_sel(b);
    e.st = ev && es && mv && mw && mr != 0 && mr == ess;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare mid-cycle after each drive
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks += 3;
        if (op_sel[0] !== e.a) begin
          failures++;
          $display("FAIL %s op_a actual=%0d expected=%0d", e.tag, op_sel[0], e.a);
        end
        if (op_sel[1] !== e.b) begin
          failures++;
          $display("FAIL %s op_b actual=%0d expected=%0d", e.tag, op_sel[1], e.b);
        end
        if (st_fwd !== e.st) begin
          failures++;
          $display("FAIL %s st_fwd actual=%0d expected=%0d", e.tag, st_fwd, e.st);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ex_src = '0; exv = 0; exw = 0; exrd = 0; exst = 0; exss = 0; mwv = 0; mww = 0; mwrd = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R1 idle pipeline after reset
    drive(5'd0, 5'd0, 0,0,5'd0, 0,5'd0, 0,0,5'd0, "R1 idle");
    // R1 producer three ahead: neither stage holds it
    drive(5'd7, 5'd8, 1,1,5'd3, 0,5'd0, 1,1,5'd4, "R1 far");
    // R2 newer producer on A
    drive(5'd6, 5'd9, 1,1,5'd6, 0,5'd0, 0,0,5'd0, "R2 ex_a");
    // R3 older producer on B
    drive(5'd1, 5'd12, 0,0,5'd0, 0,5'd0, 1,1,5'd12, "R3 wb_b");
    // R4 both stages write the same register
    drive(5'd10, 5'd10, 1,1,5'd10, 0,5'd0, 1,1,5'd10, "R4 both");
    // R5 register 0 in both stages and both sources
    drive(5'd0, 5'd0, 1,1,5'd0, 0,5'd0, 1,1,5'd0, "R5 zero");
    // R6 newer stage invalid falls back to older
    drive(5'd4, 5'd4, 0,1,5'd4, 0,5'd0, 1,1,5'd4, "R6 ex_invalid");
    // R6 newer stage not writing; older not writing either
    drive(5'd4, 5'd4, 1,0,5'd4, 0,5'd0, 1,0,5'd4, "R6 no_wen");
    // R7 A from newer, B from older
    drive(5'd2, 5'd3, 1,1,5'd2, 0,5'd0, 1,1,5'd3, "R7 split");
    // R8 load then store of the loaded register
    drive(5'd1, 5'd2, 1,0,5'd0, 1,5'd9, 1,1,5'd9, "R8 st_fwd");
    // R8 not a store
    drive(5'd1, 5'd2, 1,1,5'd0, 0,5'd9, 1,1,5'd9, "R8 not_store");
    // R8 store data register 0
    drive(5'd1, 5'd2, 1,0,5'd0, 1,5'd0, 1,1,5'd0, "R8 st_zero");
    // R8 store invalid
    drive(5'd1, 5'd2, 0,0,5'd0, 1,5'd9, 1,1,5'd9, "R8 st_invalid");
    // R9 mixed stream over a small register range, each change checked same cycle
    for (int i = 0; i < 400; i++) begin
      logic [REG_W-1:0] a, b, er, ess, mr;
      logic ev, ew, es, mv, mw;
      a = REG_W'($urandom_range(0, 3)); b = REG_W'($urandom_range(0, 3));
      er = REG_W'($urandom_range(0, 3)); ess = REG_W'($urandom_range(0, 3));
      mr = REG_W'($urandom_range(0, 3));
      ev = 1'($urandom); ew = 1'($urandom); es = 1'($urandom);
      mv = 1'($urandom); mw = 1'($urandom);
      drive(a, b, ev, ew, er, es, ess, mv, mw, mr, "R9 stream");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule